// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits at the decode stage of a five-stage in-order pipeline. It holds the fetch-to-decode instruction register and watches the instruction one stage ahead, in the decode-to-execute register. When that older instruction is a memory read whose destination register is a source of the instruction now being decoded, the loaded value does not exist yet. The block then freezes the program counter and its own instruction register, and zeroes the control word headed for the execute stage. The result is one empty slot, and the dependent instruction is decoded a second time.

On the second pass the older instruction has moved on. The decode-to-execute slot now holds the bubble, whose memory-read flag is clear, so the stall ends on its own. From then on the load result can reach the execute stage through the forwarding network.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: A stall is raised when `idex_mem_rd_i` is 1 and `idex_rt_i` equals the first source field of the decoded instruction, bits 25:21 of `dec_instr_o`.
- R2: A stall is raised when `idex_mem_rd_i` is 1 and `idex_rt_i` equals the second source field, bits 20:16 of `dec_instr_o`.
- R3: When `idex_mem_rd_i` is 0, or neither field matches, `pc_we_o` and `ifid_we_o` are 1, `ctl_zero_o` is 0 and `idex_ctl_o` equals `dec_ctl_i`.
- R4: During a stall `pc_we_o` and `ifid_we_o` are both 0 and `ctl_zero_o` is 1, all in the same cycle as the condition, with no register in between.
- R5: During a stall `idex_ctl_o` is all zeros, whatever `dec_ctl_i` carries.
- R6: On a rising clock edge where `ifid_we_o` is 1, `dec_instr_o` takes `fetch_instr_i`. Otherwise it keeps its value.
- R7: While `rst_ni` is low, `dec_instr_o` is all zeros, which decodes as a no-op.
- R8: Register number 0 gets no exemption: a memory read into register 0 followed by a reader of register 0 still stalls.
- R9: A load followed by a dependent instruction gives exactly one stalled cycle. A load followed by an independent instruction, or a non-load followed by any instruction, gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idex_mem_rd_i | input | 1 | Memory-read flag of the instruction in the decode-to-execute register |
| idex_rt_i | input | 5 | Destination register number of that instruction |
| fetch_instr_i | input | 32 | Instruction arriving from fetch |
| dec_ctl_i | input | CTL_W (4) | Control word decoded from `dec_instr_o` |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Instruction register write enable |
| ctl_zero_o | output | 1 | High when the control word is being zeroed |
| dec_instr_o | output | 32 | Instruction held for decode |
| idex_ctl_o | output | CTL_W (4) | Control word to load into the decode-to-execute register |

## Verification
The bench builds the block with its default control width of four bits, one of which is the memory-read flag. It surrounds the block with a model of the program counter, the decoder and the decode-to-execute register, so that bubbles travel through a real loop. Source and destination numbers are drawn from eight registers, which makes collisions on both fields, and on register 0, frequent under random programs. A directed prologue contains three dependent loads, one independent load and one non-load producer, and pins the total stall count to exactly three.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;

  typedef logic [REG_W-1:0]   reg_idx_t;
  typedef logic [INSTR_W-1:0] instr_t;

  localparam instr_t NOP_INSTR = '0;

  function automatic int src_lsb(input int idx);
    return (idx == 0) ? RS_LSB : RT_LSB;
  endfunction
endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect
  import ldu_pkg::*;
(
  input  logic                      ld_pending_i,
  input  reg_idx_t                  ld_dst_i,
  input  reg_idx_t [NUM_SRC-1:0]    src_i,
  output logic                      hazard_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign hit[g] = (src_i[g] == ld_dst_i);
  end

  assign hazard_o = ld_pending_i && (|hit);
endmodule

// File: rtl/ldu_fetch_reg.sv
module ldu_fetch_reg
  import ldu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  instr_t d_i,
  output instr_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= NOP_INSTR;
    else if (we_i) q_o <= d_i;
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(q_o));

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i)) |-> (q_o == $past(d_i)));

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R7: assert (q_o == NOP_INSTR);
  end
endmodule

// File: rtl/ldu_bubble.sv
module ldu_bubble #(
  parameter int CTL_W = 4
) (
  input  logic             zero_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic [CTL_W-1:0] ctl_o
);
  assign ctl_o = zero_i ? '0 : ctl_i;
endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl
  import ldu_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                idex_mem_rd_i,
  input  logic [REG_W-1:0]    idex_rt_i,
  input  logic [INSTR_W-1:0]  fetch_instr_i,
  input  logic [CTL_W-1:0]    dec_ctl_i,
  output logic                pc_we_o,
  output logic                ifid_we_o,
  output logic                ctl_zero_o,
  output logic [INSTR_W-1:0]  dec_instr_o,
  output logic [CTL_W-1:0]    idex_ctl_o
);
  logic                   stall;
  reg_idx_t [NUM_SRC-1:0] src;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src[g] = dec_instr_o[src_lsb(g) +: REG_W];
  end

  ldu_hazard_detect i_detect (
    .ld_pending_i (idex_mem_rd_i),
    .ld_dst_i     (idex_rt_i),
    .src_i        (src),
    .hazard_o     (stall)
  );

  ldu_fetch_reg i_ifid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ifid_we_o),
    .d_i    (fetch_instr_i),
    .q_o    (dec_instr_o)
  );

  ldu_bubble #(.CTL_W(CTL_W)) i_bubble (
    .zero_i (stall),
    .ctl_i  (dec_ctl_i),
    .ctl_o  (idex_ctl_o)
  );

  assign pc_we_o    = !stall;
  assign ifid_we_o  = !stall;
  assign ctl_zero_o = stall;

  assert_rs_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_mem_rd_i && idex_rt_i == dec_instr_o[RS_LSB +: REG_W]) |-> !pc_we_o);

  assert_rt_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_mem_rd_i && idex_rt_i == dec_instr_o[RT_LSB +: REG_W]) |-> !ifid_we_o);

  assert_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idex_mem_rd_i |-> (pc_we_o && idex_ctl_o == dec_ctl_i));

  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_o |-> (!ifid_we_o && ctl_zero_o));

  assert_bubble_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_zero_o |-> (idex_ctl_o == '0));
endmodule

// File: tb/test_ldu_stall_ctrl.sv
module test_ldu_stall_ctrl;
  localparam int CLK_P  = 10;
  localparam int CTL_W  = 4;
  localparam int NPROG  = 256;
  localparam int NDIR   = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pc_we_o, ifid_we_o, ctl_zero_o;
  logic [31:0] dec_instr_o;
  logic [CTL_W-1:0] idex_ctl_o;

  logic [31:0] prog [NPROG];
  int          pc;
  int          ifid_idx;
  logic [31:0] ifid_m;
  logic        idex_mr;
  logic [4:0]  idex_rt;
  logic [CTL_W-1:0] dec_ctl;
  logic        m_stall;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  // control word: bit0 mem read, bit1 reg write, bit2 mem write, bit3 branch
  function automatic logic [CTL_W-1:0] decode(input logic [31:0] ins);
    case (ins[31:26])
      6'd35:   return 4'b0011;
      6'd43:   return 4'b0100;
      6'd4:    return 4'b1000;
      6'd0:    return (ins == 32'd0) ? 4'b0000 : 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] mk_ld(input int rt, input int rs);
    return {6'd35, rs[4:0], rt[4:0], 16'h0004};
  endfunction

  function automatic logic [31:0] mk_add(input int rd, input int rs, input int rt);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, 6'd32};
  endfunction

  function automatic logic exp_stall(input logic mr, input logic [4:0] drt,
                                     input logic [31:0] ins);
    return mr && (drt == ins[25:21] || drt == ins[20:16]);
  endfunction

  assign dec_ctl = decode(dec_instr_o);
  assign m_stall = exp_stall(idex_mr, idex_rt, ifid_m);

  ldu_stall_ctrl #(.CTL_W(CTL_W)) i_ldu_stall_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .idex_mem_rd_i (idex_mr),
    .idex_rt_i     (idex_rt),
    .fetch_instr_i (prog[pc]),
    .dec_ctl_i     (dec_ctl),
    .pc_we_o       (pc_we_o),
    .ifid_we_o     (ifid_we_o),
    .ctl_zero_o    (ctl_zero_o),
    .dec_instr_o   (dec_instr_o),
    .idex_ctl_o    (idex_ctl_o)
  );

  // bench model of PC, IF/ID and the ID/EX fields fed back to the block
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc <= 0; ifid_idx <= -1; ifid_m <= 32'd0; idex_mr <= 1'b0; idex_rt <= 5'd0;
    end else begin
      idex_mr <= m_stall ? 1'b0 : decode(ifid_m)[0];
      idex_rt <= ifid_m[20:16];
      if (!m_stall) begin
        ifid_m   <= prog[pc];
        ifid_idx <= pc;
        pc       <= (pc + 1) % NPROG;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : wdog
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic prev_st;
    logic [31:0] prev_dec;
    int dir_stalls;
    logic dir_done;
    void'($urandom(32'd4242));
    // directed prologue
    prog[0] = mk_ld(2, 1);
    prog[1] = mk_add(3, 2, 4);      // rs depends: stall
    prog[2] = mk_ld(5, 6);
    prog[3] = mk_add(7, 8, 5);      // rt depends: stall
    prog[4] = mk_ld(9, 1);
    prog[5] = mk_add(10, 11, 12);   // independent
    prog[6] = mk_add(13, 14, 15);
    prog[7] = mk_add(1, 15, 15);    // producer not a load
    prog[8] = mk_ld(0, 3);
    prog[9] = mk_add(4, 0, 5);      // register 0 still stalls
    for (int i = NDIR; i < NPROG; i++) begin
      int a, b, c;
      a = $urandom_range(0, 7); b = $urandom_range(0, 7); c = $urandom_range(0, 7);
      if ($urandom_range(0, 2) == 0) prog[i] = mk_ld(a, b);
      else                           prog[i] = mk_add(a, b, c);
    end

    repeat (3) @(negedge clk_i);
    chk("R7 reset instr", dec_instr_o, 32'd0);
    chk("R7 reset pc_we", {31'd0, pc_we_o}, 32'd1);
    chk("R7 reset zero", {31'd0, ctl_zero_o}, 32'd0);
    rst_ni = 1'b1;

    prev_st = 1'b0; prev_dec = 32'd0; dir_stalls = 0; dir_done = 1'b0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      logic st;
      @(negedge clk_i);
      st = m_stall;
      chk("R6 ifid content", dec_instr_o, ifid_m);
      if (st) begin
        if (idex_rt == ifid_m[25:21]) chk("R1 rs stall", {31'd0, ctl_zero_o}, 32'd1);
        else                          chk("R2 rt stall", {31'd0, ctl_zero_o}, 32'd1);
        if (idex_rt == 5'd0)          chk("R8 reg0 stall", {31'd0, ctl_zero_o}, 32'd1);
        chk("R4 pc freeze", {31'd0, pc_we_o}, 32'd0);
        chk("R4 ifid freeze", {31'd0, ifid_we_o}, 32'd0);
        chk("R5 zero ctl", {28'd0, idex_ctl_o}, 32'd0);
      end else begin
        chk("R3 pc_we", {31'd0, pc_we_o}, 32'd1);
        chk("R3 ifid_we", {31'd0, ifid_we_o}, 32'd1);
        chk("R3 no zero", {31'd0, ctl_zero_o}, 32'd0);
        chk("R3 ctl pass", {28'd0, idex_ctl_o}, {28'd0, decode(ifid_m)});
      end
      if (prev_st) begin
        chk("R9 single bubble", {31'd0, ctl_zero_o}, 32'd0);
        chk("R6 hold", dec_instr_o, prev_dec);
      end
      if (ifid_idx >= 0 && ifid_idx < NDIR && ctl_zero_o) dir_stalls++;
      if (!dir_done && ifid_idx >= NDIR) begin
        dir_done = 1'b1;
        chk("R9 directed stall count", dir_stalls, 32'd3);
      end
      prev_st = ctl_zero_o;
      prev_dec = dec_instr_o;
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule